// File: doc/BRIEF.md
# Flash Block-Protect Write Guard

This block sits between the command layer of a serial NOR flash model and its memory array. It keeps the protection fields of the status register and decides, for every program or erase request, whether the target byte address lies inside the protected region. The protected region is a power-of-two number of sectors. Depending on the anchor bit, it grows downward from the last sector or upward from sector 0.

A status-register write delivers one data byte on `sr_wr_i`/`sr_wdata_i`. From it the block loads the block-protect field, the anchor bit, the optional fourth protect bit and the status-register-write-disable flag. The status byte for a read is built combinationally on `sr_rdata_o`, with the write-enable latch taken from `wel_i`. A write request on `wr_req_i`/`wr_addr_i` is judged against the stored setting. One cycle later the block gives either a memory write strobe with the registered address, or a one-cycle violation pulse. Parameters set the sector size, the sector count, and whether the anchor bit and the fourth protect bit exist.

Top module: `flash_bp_guard`

## Requirements
- R1: After reset, every protection bit and the write-disable flag read 0, and a write to any sector is allowed.
- R2: A status write loads the protect bits from data bits 2, 3 and 4 (least significant first). A status read returns them at the same bit positions. Without a status write they hold their value.
- R3: The anchor bit is status bit 5. When `HAS_TB`=1 it is stored and read back. When `HAS_TB`=0 a written 1 is ignored, reads as 0, and the region stays anchored at the top.
- R4: The fourth protect bit is status bit 6 and forms the field's most significant bit, giving values 0 to 15. When `HAS_BP3`=0 it is ignored and reads as 0.
- R5: Status bit 7 stores the write-disable flag from data bit 7. Bit 1 reports `wel_i`. Bit 0 reads 0.
- R6: A protect field value of 0 protects no sector.
- R7: With the anchor bit 0 and field value N>0, a write to sector index s is blocked when s + 2^(N-1) >= sector count, where s = address >> `SECTOR_LOG2`.
- R8: With the anchor bit 1 and field value N>0, a write to sector s is blocked when s < 2^(N-1).
- R9: The protected count saturates at the sector count, so a field value with 2^(N-1) >= sector count protects every sector.
- R10: A request in cycle t gives outputs in cycle t+1. If the write is allowed, `mem_we_o`=1 and `mem_addr_o` equals the request address. If it is blocked, `wp_viol_o`=1 for exactly one cycle and `mem_we_o`=0. With no request, both outputs stay 0.
- R11: A request in the same cycle as a status write is judged on the setting held before that write. The new setting applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sr_wr_i | input | 1 | Status-register write strobe |
| sr_wdata_i | input | 8 | Status-register write data byte |
| wel_i | input | 1 | Write-enable latch state, reported in bit 1 |
| sr_rdata_o | output | 8 | Status byte for a status read |
| wr_req_i | input | 1 | Program/erase write request |
| wr_addr_i | input | SECTOR_LOG2+SECTOR_COUNT_LOG2 | Byte address of the request |
| mem_we_o | output | 1 | Memory write strobe, registered |
| mem_addr_o | output | SECTOR_LOG2+SECTOR_COUNT_LOG2 | Registered request address |
| wp_viol_o | output | 1 | One-cycle write-protect violation pulse |

## Verification
The bench probes the exact edges of the protected range in both anchor directions, such as the last sector versus the one below it and sector 2^(N-1)-1 versus 2^(N-1). An off-by-one comparison would let through a protected sector or block a free one. It drives field values past the saturation point and expects the whole array to be protected; a shift that wrapped would leave sectors writable. A status write and a request land in the same cycle, so a design that judged the request on the new setting would block or pass the wrong write. A second instance built without the optional bits receives writes that set bits 5 and 6, and the bench expects them to read 0 and have no effect on protection.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  // Stored status fields relevant to write protection.
  typedef struct packed {
    logic       srwd;   // status-register write disable (bit 7)
    logic       bp3;    // optional fourth protect bit (bit 6)
    logic       tb;     // anchor: 0 = top, 1 = bottom (bit 5)
    logic [2:0] bp_lo;  // protect bits 2..4
  } wp_cfg_t;

  localparam int unsigned SR_BP_LSB = 2;
  localparam int unsigned SR_TB_BIT = 5;
  localparam int unsigned SR_BP3_BIT = 6;
  localparam int unsigned SR_SRWD_BIT = 7;

endpackage

// File: rtl/fl_wp_status.sv
module fl_wp_status
  import flash_wp_pkg::*;
#(
  parameter bit HAS_TB  = 1'b1,
  parameter bit HAS_BP3 = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  input  logic       wel_i,
  output wp_cfg_t    cfg_o,
  output logic [7:0] rdata_o
);

  wp_cfg_t cfg_d, cfg_q;
  logic    tb_nxt, bp3_nxt;
  logic    unused_wdata;

  assign unused_wdata = ^wdata_i[1:0];

  // Optional bits: either taken from the data byte or held at 0.
  generate
    if (HAS_TB) begin : g_tb
      assign tb_nxt = wdata_i[SR_TB_BIT];
    end else begin : g_no_tb
      logic unused_tb;
      assign unused_tb = wdata_i[SR_TB_BIT];
      assign tb_nxt    = 1'b0;
    end
    if (HAS_BP3) begin : g_bp3
      assign bp3_nxt = wdata_i[SR_BP3_BIT];
    end else begin : g_no_bp3
      logic unused_bp3;
      assign unused_bp3 = wdata_i[SR_BP3_BIT];
      assign bp3_nxt    = 1'b0;
    end
  endgenerate

  // Next-state logic with explicit load enable.
  always_comb begin
    cfg_d = cfg_q;
    if (wr_en_i) begin
      cfg_d.srwd  = wdata_i[SR_SRWD_BIT];
      cfg_d.bp3   = bp3_nxt;
      cfg_d.tb    = tb_nxt;
      cfg_d.bp_lo = wdata_i[SR_BP_LSB +: 3];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {cfg_q.srwd, cfg_q.bp3, cfg_q.tb, cfg_q.bp_lo, wel_i, 1'b0};

endmodule

// File: rtl/fl_wp_range.sv
module fl_wp_range #(
  parameter int unsigned SECTOR_COUNT_LOG2 = 9
) (
  input  logic [3:0]                 bp_i,
  input  logic                       tb_i,
  output logic [SECTOR_COUNT_LOG2:0] base_o,   // first protected sector
  output logic [SECTOR_COUNT_LOG2:0] limit_o   // one past last protected sector
);

  localparam int unsigned CW = SECTOR_COUNT_LOG2 + 1;
  localparam logic [CW-1:0] NSEC = CW'(1) << SECTOR_COUNT_LOG2;

  logic [CW-1:0] cnt;

  // Protected-sector count: 0 for field 0, else 2^(N-1) saturated at NSEC.
  always_comb begin
    cnt = '0;
    for (int i = 1; i < 16; i++) begin
      if (bp_i == 4'(i)) begin
        if (i - 1 >= int'(SECTOR_COUNT_LOG2)) begin
          cnt = NSEC;
        end else begin
          cnt = CW'(1) << (i - 1);
        end
      end
    end
  end

  // Half-open range [base, limit); an empty range when cnt is 0.
  always_comb begin
    if (tb_i) begin
      base_o  = '0;
      limit_o = cnt;
    end else begin
      base_o  = NSEC - cnt;
      limit_o = NSEC;
    end
  end

endmodule

// File: rtl/fl_wp_gate.sv
module fl_wp_gate #(
  parameter int unsigned SECTOR_LOG2       = 16,
  parameter int unsigned SECTOR_COUNT_LOG2 = 9,
  localparam int unsigned ADDR_W = SECTOR_LOG2 + SECTOR_COUNT_LOG2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [SECTOR_COUNT_LOG2:0] base_i,
  input  logic [SECTOR_COUNT_LOG2:0] limit_i,
  output logic                       mem_we_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic                       viol_o
);

  logic [SECTOR_COUNT_LOG2:0] sector;
  logic                       in_range;
  logic                       we_d, we_q, viol_d, viol_q;
  logic [ADDR_W-1:0]          addr_d, addr_q;

  // Sector index is the address shifted right by the sector size exponent.
  assign sector   = {1'b0, addr_i[ADDR_W-1:SECTOR_LOG2]};
  assign in_range = (sector >= base_i) && (sector < limit_i);

  always_comb begin
    we_d   = req_i & ~in_range;
    viol_d = req_i &  in_range;
    addr_d = addr_q;
    if (req_i) begin
      addr_d = addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      viol_q <= 1'b0;
      addr_q <= '0;
    end else begin
      we_q   <= we_d;
      viol_q <= viol_d;
      addr_q <= addr_d;
    end
  end

  assign mem_we_o   = we_q;
  assign viol_o     = viol_q;
  assign mem_addr_o = addr_q;

endmodule

// File: rtl/flash_bp_guard.sv
module flash_bp_guard
  import flash_wp_pkg::*;
#(
  parameter int unsigned SECTOR_LOG2       = 16,
  parameter int unsigned SECTOR_COUNT_LOG2 = 9,
  parameter bit          HAS_TB            = 1'b1,
  parameter bit          HAS_BP3           = 1'b1,
  localparam int unsigned ADDR_W = SECTOR_LOG2 + SECTOR_COUNT_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_wdata_i,
  input  logic              wel_i,
  output logic [7:0]        sr_rdata_o,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              wp_viol_o
);

  wp_cfg_t                    cfg;
  logic [SECTOR_COUNT_LOG2:0] base, limit;
  logic                       unused_srwd;

  // The write-disable flag is only reported here; gating status writes
  // on it belongs to the command layer.
  assign unused_srwd = cfg.srwd;

  fl_wp_status #(
    .HAS_TB (HAS_TB),
    .HAS_BP3(HAS_BP3)
  ) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(sr_wr_i),
    .wdata_i(sr_wdata_i),
    .wel_i  (wel_i),
    .cfg_o  (cfg),
    .rdata_o(sr_rdata_o)
  );

  fl_wp_range #(
    .SECTOR_COUNT_LOG2(SECTOR_COUNT_LOG2)
  ) u_range (
    .bp_i   ({cfg.bp3, cfg.bp_lo}),
    .tb_i   (cfg.tb),
    .base_o (base),
    .limit_o(limit)
  );

  fl_wp_gate #(
    .SECTOR_LOG2      (SECTOR_LOG2),
    .SECTOR_COUNT_LOG2(SECTOR_COUNT_LOG2)
  ) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (wr_req_i),
    .addr_i    (wr_addr_i),
    .base_i    (base),
    .limit_i   (limit),
    .mem_we_o  (mem_we_o),
    .mem_addr_o(mem_addr_o),
    .viol_o    (wp_viol_o)
  );

endmodule

// File: rtl/flash_bp_guard_chk.sv
module flash_bp_guard_chk #(
  parameter int unsigned SECTOR_LOG2       = 16,
  parameter int unsigned SECTOR_COUNT_LOG2 = 9,
  parameter bit          HAS_TB            = 1'b1,
  parameter bit          HAS_BP3           = 1'b1,
  localparam int unsigned ADDR_W = SECTOR_LOG2 + SECTOR_COUNT_LOG2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sr_wr_i,
  input logic [7:0]        sr_wdata_i,
  input logic [7:0]        sr_rdata_o,
  input logic              wr_req_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              wp_viol_o
);

  logic [SECTOR_COUNT_LOG2-1:0] req_sec;
  logic                         bp_zero;
  assign req_sec = wr_addr_i[ADDR_W-1:SECTOR_LOG2];
  assign bp_zero = (sr_rdata_o[4:2] == 3'd0) && !sr_rdata_o[6];

  assert_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_i |=> (!mem_we_o && !wp_viol_o));

  assert_verdict_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i |=> (mem_we_o != wp_viol_o));

  assert_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i |=> (mem_addr_o == $past(wr_addr_i)));

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_i |=> (sr_rdata_o[4:2] == $past(sr_wdata_i[4:2])));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_wr_i |=> $stable(sr_rdata_o[7:2]));

  assert_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && bp_zero) |=> mem_we_o);

  assert_top_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && !bp_zero && !sr_rdata_o[5] && (&req_sec)) |=> wp_viol_o);

  assert_bottom_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && !bp_zero && sr_rdata_o[5] && (req_sec == '0)) |=> wp_viol_o);

  generate
    if (!HAS_TB) begin : g_no_tb
      assert_tb_absent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sr_wr_i |=> !sr_rdata_o[5]);
    end
    if (!HAS_BP3) begin : g_no_bp3
      assert_bp3_absent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sr_wr_i |=> !sr_rdata_o[6]);
    end
  endgenerate

endmodule

bind flash_bp_guard flash_bp_guard_chk #(
  .SECTOR_LOG2      (SECTOR_LOG2),
  .SECTOR_COUNT_LOG2(SECTOR_COUNT_LOG2),
  .HAS_TB           (HAS_TB),
  .HAS_BP3          (HAS_BP3)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sr_wr_i   (sr_wr_i),
  .sr_wdata_i(sr_wdata_i),
  .sr_rdata_o(sr_rdata_o),
  .wr_req_i  (wr_req_i),
  .wr_addr_i (wr_addr_i),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o),
  .wp_viol_o (wp_viol_o)
);

// File: tb/tb_flash_bp_guard.sv
module tb_flash_bp_guard;

  localparam int SL2 = 16;
  localparam int CL2 = 9;
  localparam int NSEC = 1 << CL2;
  localparam int AW = SL2 + CL2;

  typedef struct {
    logic          we;
    logic          viol;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sr_wr_i;
  logic [7:0]    sr_wdata_i;
  logic          wel_i;
  logic [7:0]    sr_rdata_o, min_rdata;
  logic          wr_req_i;
  logic [AW-1:0] wr_addr_i;
  logic          mem_we_o, wp_viol_o, min_we, min_viol;
  logic [AW-1:0] mem_addr_o, min_addr;

  int   tests = 0;
  int   fails = 0;
  exp_t q[$];
  logic [7:0] m_sr;   // last written status byte

  always #2 clk = ~clk;

  flash_bp_guard #(.SECTOR_LOG2(SL2), .SECTOR_COUNT_LOG2(CL2),
                   .HAS_TB(1'b1), .HAS_BP3(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sr_wr_i(sr_wr_i), .sr_wdata_i(sr_wdata_i),
    .wel_i(wel_i), .sr_rdata_o(sr_rdata_o), .wr_req_i(wr_req_i),
    .wr_addr_i(wr_addr_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .wp_viol_o(wp_viol_o));

  flash_bp_guard #(.SECTOR_LOG2(SL2), .SECTOR_COUNT_LOG2(CL2),
                   .HAS_TB(1'b0), .HAS_BP3(1'b0)) dut_min (
    .clk_i(clk), .rst_ni(rst_n), .sr_wr_i(sr_wr_i), .sr_wdata_i(sr_wdata_i),
    .wel_i(wel_i), .sr_rdata_o(min_rdata), .wr_req_i(wr_req_i),
    .wr_addr_i(wr_addr_i), .mem_we_o(min_we), .mem_addr_o(min_addr),
    .wp_viol_o(min_viol));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected verdict from the requirement formulas (R6..R9, R3/R4 variants).
  function automatic bit blocked(input int sec, input logic [7:0] sr,
                                 input bit has_tb, input bit has_bp3);
    int bp;
    int cnt;
    bit tb;
    bp = int'(sr[4:2]) + ((has_bp3 && sr[6]) ? 8 : 0);
    tb = has_tb && sr[5];
    if (bp == 0) return 1'b0;
    cnt = (bp - 1 >= CL2) ? NSEC : (1 << (bp - 1));
    if (tb) return sec < cnt;
    return (sec + cnt) >= NSEC;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] sr, input bit has_tb,
                                        input bit has_bp3, input logic wel);
    return {sr[7], has_bp3 & sr[6], has_tb & sr[5], sr[4:2], wel, 1'b0};
  endfunction

  task automatic sr_write(input logic [7:0] d, input string tag);
    @(negedge clk);
    sr_wr_i    = 1'b1;
    sr_wdata_i = d;
    @(negedge clk);
    sr_wr_i = 1'b0;
    m_sr    = d;
    chk(sr_rdata_o == exp_rd(d, 1, 1, wel_i), tag, {24'd0, sr_rdata_o},
        {24'd0, exp_rd(d, 1, 1, wel_i)});
  endtask

  // Driver: one-cycle request, expected item pushed for the monitor.
  task automatic wreq(input int sec, input string tag, input bit with_sr,
                      input logic [7:0] d, input bit chk_min);
    exp_t e;
    logic [AW-1:0] a;
    bit mb;
    a = AW'(sec) << SL2 | AW'(12'h5a3);
    @(negedge clk);
    wr_req_i  = 1'b1;
    wr_addr_i = a;
    if (with_sr) begin
      sr_wr_i    = 1'b1;
      sr_wdata_i = d;
    end
    e.viol = blocked(sec, m_sr, 1, 1);
    e.we   = !e.viol;
    e.addr = a;
    e.tag  = tag;
    q.push_back(e);
    mb = blocked(sec, m_sr, 0, 0);
    @(negedge clk);
    wr_req_i = 1'b0;
    sr_wr_i  = 1'b0;
    if (with_sr) m_sr = d;
    if (chk_min) begin
      chk(min_viol == mb && min_we == !mb, {tag, " (no optional bits)"},
          {30'd0, min_we, min_viol}, {30'd0, !mb, mb});
    end
  endtask

  // Monitor: compares the registered verdict one cycle after each request.
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && wr_req_i) begin
        exp_t e;
        @(negedge clk);
        e = q.pop_front();
        chk(mem_we_o == e.we && wp_viol_o == e.viol && mem_addr_o == e.addr,
            e.tag, {5'd0, mem_we_o, wp_viol_o, mem_addr_o},
            {5'd0, e.we, e.viol, e.addr});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sr_wr_i = 1'b0; sr_wdata_i = '0; wel_i = 1'b0;
    wr_req_i = 1'b0; wr_addr_i = '0; m_sr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sr_rdata_o == 8'h00, "R1 reset status", {24'd0, sr_rdata_o}, 32'h0);
    wreq(0, "R1 sector 0 open after reset", 0, 8'h0, 0);
    wreq(NSEC - 1, "R1 last sector open after reset", 0, 8'h0, 0);

    // R5: write-enable latch and write-disable flag
    wel_i = 1'b1;
    @(negedge clk);
    chk(sr_rdata_o == 8'h02, "R5 wel reported in bit 1", {24'd0, sr_rdata_o}, 32'h02);

    // R2/R7: one top sector
    sr_write(8'h04, "R2 protect field value 1 readback");
    wreq(NSEC - 1, "R7 top N=1 last sector blocked", 0, 8'h0, 0);
    wreq(NSEC - 2, "R7 top N=1 next sector allowed", 0, 8'h0, 0);
    sr_write(8'h0C, "R2 protect field value 3 readback");
    wreq(NSEC - 4, "R7 top N=3 edge blocked", 0, 8'h0, 0);
    wreq(NSEC - 5, "R7 top N=3 below edge allowed", 0, 8'h0, 0);

    // R3/R8: bottom anchoring
    sr_write(8'h2C, "R3 anchor bit readback");
    wreq(3, "R8 bottom N=3 sector 3 blocked", 0, 8'h0, 0);
    wreq(4, "R8 bottom N=3 sector 4 allowed", 0, 8'h0, 0);
    wreq(NSEC - 1, "R8 bottom N=3 last sector allowed", 0, 8'h0, 0);

    // R4/R9: fourth bit and saturation
    sr_write(8'h44, "R4 field value 9 readback");
    wreq(256, "R4 top N=9 sector 256 blocked", 0, 8'h0, 0);
    wreq(255, "R4 top N=9 sector 255 allowed", 0, 8'h0, 0);
    sr_write(8'h48, "R4 field value 10 readback");
    wreq(0, "R9 N=10 saturates, sector 0 blocked", 0, 8'h0, 0);
    sr_write(8'h5C, "R4 field value 15 readback");
    wreq(0, "R9 N=15 sector 0 blocked", 0, 8'h0, 0);
    wreq(NSEC - 1, "R9 N=15 last sector blocked", 0, 8'h0, 0);

    // R5/R6: write-disable flag, field 0 opens everything
    sr_write(8'h80, "R5 write-disable flag readback");
    wreq(0, "R6 field 0 sector 0 allowed", 0, 8'h0, 0);
    wreq(NSEC - 1, "R6 field 0 last sector allowed", 0, 8'h0, 0);

    // R11: status write and request in the same cycle
    wreq(NSEC - 1, "R11 request beside status write uses old setting", 1, 8'h1C, 0);
    wreq(NSEC - 1, "R11 new setting applies next cycle", 0, 8'h0, 0);

    // R3/R4: instance without optional bits ignores bits 5 and 6
    sr_write(8'h7C, "R3 R4 full-featured readback");
    chk(min_rdata == 8'h1E, "R3 R4 bits 5 and 6 ignored without options",
        {24'd0, min_rdata}, 32'h1E);
    wreq(0, "R3 ignored anchor keeps top region", 0, 8'h0, 1);
    wreq(NSEC - 1, "R4 ignored fourth bit keeps N=7 top", 0, 8'h0, 1);
    wreq(NSEC - 65, "R4 N=7 below 64-sector region allowed", 0, 8'h0, 1);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10 every request produced a verdict", q.size(), 0);
    chk(!mem_we_o && !wp_viol_o, "R10 outputs idle without request",
        {30'd0, mem_we_o, wp_viol_o}, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule